// File: doc/BRIEF.md
# Diagnostic Master-Reset Sequencer

This block brings a microcoded processor and its memory controller out of reset by playing a fixed script of diagnostic function commands. It drives them onto a simple command port: a function code, a write-data word and a one-cycle strobe. It then waits for a completion pulse before it issues the next command. The script has two halves. Between them sits a bounded loop that lines up the memory-controller clock phase.

After the first half, the sequencer waits a programmable number of cycles and issues a diagnostic read. It inspects one status bit of the returned word, which tells it whether a phase change is still pending. If that bit is set, it issues a single-step clock command and polls again. At most five steps are allowed. If the bit is still set on the read that follows the fifth step, an error flag is raised and the script carries on. The second half then enables code decoding, sets the memory reset flop through a bus load, and writes a setup word to the memory controller.

Software or a front-end controller pulses `start` and watches `busy`, `done` and `error`. The diagnostic bus transceiver answers each strobe with `cmd_done` and, for reads, presents the returned word on `rd_word`.

Top module: `diag_reset_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done`, `cmd_stb` and `error` are 0, and `cmd_func` and `cmd_wdata` are 0.
- R2: A `start` pulse sampled while idle raises `busy` on the next cycle, and the first command strobe appears in that same cycle. A `start` sampled while busy has no effect on the command stream or on the flags.
- R3: The first half issues these eleven codes in this order (octal, 7-bit `cmd_func`), all with `cmd_wdata` 0: 012 halt run, 045 default clock source and rate, 000 stop clock, 046 reset parity-check registers, 047 clear cycle disables and error-stop enables, 042 clear burst counter low half, 043 clear burst counter high half, 044 set processor clock disables, 001 start clock, 070 initialise I/O channels, 042 clear burst counter low half again.
- R4: Each strobe lasts exactly one cycle. No further strobe appears until `cmd_done` has been sampled for the outstanding command. A `cmd_done` sampled while no command is outstanding is ignored.
- R5: Every status read uses code 162 octal with data 0. Its strobe appears exactly POLL_WAIT+1 cycles after the cycle in which `cmd_done` was sampled for the command before it, which is the last first-half command or a step.
- R6: The status bit is bit 32 of `rd_word` counted big-endian (bit 0 is the MSB), which is vector index 3 of `rd_word[35:0]`. It is sampled with the read's `cmd_done`, and the other 35 bits have no effect. A clear bit ends the loop, and the second half starts next.
- R7: A set status bit, when fewer than 5 steps have been issued in this run, causes one step command (code 002 octal, data 0) followed by another wait and read. No run issues more than 5 steps.
- R8: If the bit is set on the read that follows the fifth step, `error` rises and the second half still runs. `error` then holds until the next accepted `start` or reset.
- R9: The second half issues, in order: 004 conditional step (data 0), 006 clear reset (data 0), 067 enable decoding (data 0), 077 bus load (data 0), 071 write memory controller with data 120 octal.
- R10: `done` is high for exactly one cycle, the cycle after `cmd_done` is sampled for the final command. `busy` is high in that cycle and low in the next one.
- R11: A synchronous active-low reset during a run returns the block to idle with `error` cleared and no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run the reset script |
| cmd_done | input | 1 | Completion pulse for the outstanding command |
| rd_word | input | 36 | Word returned by a diagnostic read |
| cmd_func | output | 7 | Diagnostic function code, valid with strobe |
| cmd_wdata | output | 36 | Write data, valid with strobe |
| cmd_stb | output | 1 | One-cycle command strobe |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Phase synchronisation failed in the last run |

## Verification
Several results have fixed latencies. `busy` and the first strobe are due one cycle after `start` is sampled. Each status read is due POLL_WAIT+1 cycles after the acknowledgement that precedes it. `done` is due one cycle after the final acknowledgement, and `busy` falls one cycle after that. The bench keeps a behavioural model that advances on every rising edge from the same inputs. It compares `busy`, `done` and `error` with the model at each falling edge, so every flag is checked in the exact cycle it is due. Each strobe is popped against a queue of expected commands, and the cycle distance to the preceding acknowledgement is checked on every read.

// File: rtl/diag_rst_pkg.sv
// Package: shared widths, command codes and FSM state type for the
// diagnostic master-reset sequencer. Assumes 7-bit function codes and a
// 36-bit diagnostic data word.
package diag_rst_pkg;

    localparam int FUNC_W     = 7;
    localparam int DATA_W     = 36;
    localparam int SCRIPT_LEN = 16;
    localparam int PH1_LEN    = 11;
    localparam int IDX_W      = $clog2(SCRIPT_LEN);
    localparam int PH1_LAST   = PH1_LEN - 1;
    localparam int SCRIPT_END = SCRIPT_LEN - 1;

    typedef logic [FUNC_W-1:0] func_t;
    typedef logic [DATA_W-1:0] data_t;

    // Codes used outside the fixed script table
    localparam func_t CODE_READ = 7'o162;
    localparam func_t CODE_STEP = 7'o002;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CMD_WAIT,
        ST_DLY,
        ST_RD,
        ST_RD_WAIT,
        ST_STEP,
        ST_STEP_WAIT,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/diag_rst_script.sv
// Module: fixed reset script table. Maps a script index to a function code
// and write data. Indices 0..10 form the first half and 11..15 the second.
// Purely combinational; assumes the index is always within the script.
module diag_rst_script
    import diag_rst_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output func_t            code,
    output data_t            wdata
);

    // Look up code and data for the current script position
    always_comb begin
        wdata = '0;
        unique case (idx)
            4'd0:  code = 7'o012;
            4'd1:  code = 7'o045;
            4'd2:  code = 7'o000;
            4'd3:  code = 7'o046;
            4'd4:  code = 7'o047;
            4'd5:  code = 7'o042;
            4'd6:  code = 7'o043;
            4'd7:  code = 7'o044;
            4'd8:  code = 7'o001;
            4'd9:  code = 7'o070;
            4'd10: code = 7'o042;
            4'd11: code = 7'o004;
            4'd12: code = 7'o006;
            4'd13: code = 7'o067;
            4'd14: code = 7'o077;
            4'd15: begin
                code  = 7'o071;
                wdata = data_t'(36'o120);
            end
            default: code = '0;
        endcase
    end

endmodule

// File: rtl/diag_rst_timer.sv
// Module: poll delay timer. A load pulse starts a countdown, and expired is
// high on the last of WAIT_CYC cycles after the load. Assumes WAIT_CYC >= 1.
module diag_rst_timer #(
    parameter int WAIT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count down from the loaded value and hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(WAIT_CYC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/diag_rst_fsm.sv
// Module: sequencing FSM. Walks the script, runs the bounded poll-and-step
// loop between the halves and keeps the error flag. Assumes cmd_done comes
// no earlier than the cycle after a strobe.
module diag_rst_fsm
    import diag_rst_pkg::*;
#(
    parameter int MAX_STEPS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_done,
    input  logic             stat_bit,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [IDX_W-1:0] idx,
    output logic             stb,
    output logic             sel_read,
    output logic             sel_step,
    output logic             busy,
    output logic             done,
    output logic             error
);

    localparam int STEP_W = $clog2(MAX_STEPS + 1);

    seq_state_t        state;
    logic [STEP_W-1:0] steps;
    logic              last_ph1;
    logic              last_all;

    assign last_ph1 = (idx == IDX_W'(PH1_LAST));
    assign last_all = (idx == IDX_W'(SCRIPT_END));

    // Advance the sequence state, the script index, the step count and the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            steps <= '0;
            error <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_CMD;
                    idx   <= '0;
                    error <= 1'b0;
                end
                ST_CMD: state <= ST_CMD_WAIT;
                ST_CMD_WAIT: if (cmd_done) begin
                    idx <= idx + 1'b1;
                    if (last_ph1) begin
                        state <= ST_DLY;
                        steps <= '0;
                    end else if (last_all) begin
                        state <= ST_FIN;
                    end else begin
                        state <= ST_CMD;
                    end
                end
                ST_DLY: if (tmr_expired) state <= ST_RD;
                ST_RD: state <= ST_RD_WAIT;
                ST_RD_WAIT: if (cmd_done) begin
                    if (!stat_bit) begin
                        state <= ST_CMD;
                    end else if (steps == STEP_W'(MAX_STEPS)) begin
                        error <= 1'b1;
                        state <= ST_CMD;
                    end else begin
                        state <= ST_STEP;
                    end
                end
                ST_STEP: state <= ST_STEP_WAIT;
                ST_STEP_WAIT: if (cmd_done) begin
                    steps <= steps + 1'b1;
                    state <= ST_DLY;
                end
                ST_FIN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode state into strobe, selects, flags and timer load
    always_comb begin
        stb      = (state == ST_CMD) || (state == ST_RD) || (state == ST_STEP);
        sel_read = (state == ST_RD);
        sel_step = (state == ST_STEP);
        busy     = (state != ST_IDLE);
        done     = (state == ST_FIN);
        tmr_load = cmd_done && (((state == ST_CMD_WAIT) && last_ph1) ||
                                (state == ST_STEP_WAIT));
    end

endmodule

// File: rtl/diag_reset_sequencer.sv
// Module: top of the diagnostic master-reset sequencer. Joins the script
// table, the poll timer and the FSM, extracts the status bit from the read
// word and drives the command port. Outputs are zero when no strobe is up.
module diag_reset_sequencer
    import diag_rst_pkg::*;
#(
    parameter int POLL_WAIT = 4,
    parameter int MAX_STEPS = 5,
    parameter int STAT_BIT  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_done,
    input  logic [DATA_W-1:0] rd_word,
    output logic [FUNC_W-1:0] cmd_func,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_stb,
    output logic              busy,
    output logic              done,
    output logic              error
);

    // Big-endian bit number converted to a one-hot mask on the vector
    localparam data_t STAT_MASK = data_t'(1) << (DATA_W - 1 - STAT_BIT);

    logic             stat_bit;
    logic             tmr_load;
    logic             tmr_expired;
    logic [IDX_W-1:0] idx;
    logic             stb;
    logic             sel_read;
    logic             sel_step;
    func_t            scr_code;
    data_t            scr_data;

    assign stat_bit = |(rd_word & STAT_MASK);

    diag_rst_script u_script (
        .idx   (idx),
        .code  (scr_code),
        .wdata (scr_data)
    );

    diag_rst_timer #(
        .WAIT_CYC (POLL_WAIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    diag_rst_fsm #(
        .MAX_STEPS (MAX_STEPS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmd_done    (cmd_done),
        .stat_bit    (stat_bit),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .idx         (idx),
        .stb         (stb),
        .sel_read    (sel_read),
        .sel_step    (sel_step),
        .busy        (busy),
        .done        (done),
        .error       (error)
    );

    // Select the command presented on the port
    always_comb begin
        cmd_stb   = stb;
        cmd_func  = '0;
        cmd_wdata = '0;
        if (stb) begin
            if (sel_read) begin
                cmd_func = CODE_READ;
            end else if (sel_step) begin
                cmd_func = CODE_STEP;
            end else begin
                cmd_func  = scr_code;
                cmd_wdata = scr_data;
            end
        end
    end

endmodule

// File: rtl/diag_reset_sequencer_chk.sv
// Module: property checker bound to the sequencer top. Observes ports only,
// plus a local count of step strobes per run.
module diag_reset_sequencer_chk
    import diag_rst_pkg::*;
#(
    parameter int MAX_STEPS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [FUNC_W-1:0] cmd_func,
    input logic              cmd_stb,
    input logic              busy,
    input logic              done,
    input logic              error
);

    int step_cnt;

    // Count step strobes within one run
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            step_cnt <= 0;
        end else if (cmd_stb && (cmd_func == CODE_STEP)) begin
            step_cnt <= step_cnt + 1;
        end
    end

    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    p_stb_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> busy);

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && cmd_stb));

    p_step_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_cnt <= MAX_STEPS);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(error));

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !error);

    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> (!busy && !error && !cmd_stb));

endmodule

bind diag_reset_sequencer diag_reset_sequencer_chk #(
    .MAX_STEPS (MAX_STEPS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_func (cmd_func),
    .cmd_stb  (cmd_stb),
    .busy     (busy),
    .done     (done),
    .error    (error)
);

// File: tb/diag_reset_sequencer_tb.sv
// Bench: behavioural model of the reset script plus a command responder.
// Flags are compared with the model on every falling edge.
module diag_reset_sequencer_tb;

    localparam int W     = 4;
    localparam int MAXST = 5;

    typedef struct packed {
        logic [6:0]  code;
        logic [35:0] data;
        logic        last;
        logic        errs;
        logic        prepoll;
        logic [1:0]  grp;   // 0 first half, 1 read, 2 step, 3 second half
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_done = 1'b0;
    logic [35:0] rd_word = '0;
    logic [6:0]  cmd_func;
    logic [35:0] cmd_wdata;
    logic        cmd_stb;
    logic        busy;
    logic        done;
    logic        error;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    exp_t q[$];
    exp_t cur;
    bit   pend = 0;
    int   wcnt = 0;
    int   lat  = 0;
    bit   stray_en = 0;
    int   kset = 0;
    int   rd_idx = 0;
    int   pp_cyc = 0;
    bit   o_last = 0;
    bit   o_err  = 0;
    bit   mon_en = 0;
    bit   m_busy = 0;
    bit   m_done = 0;
    bit   m_err  = 0;

    always #5 clk = ~clk;

    diag_reset_sequencer #(
        .POLL_WAIT (W),
        .MAX_STEPS (MAXST),
        .STAT_BIT  (32)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_done  (cmd_done),
        .rd_word   (rd_word),
        .cmd_func  (cmd_func),
        .cmd_wdata (cmd_wdata),
        .cmd_stb   (cmd_stb),
        .busy      (busy),
        .done      (done),
        .error     (error)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [6:0] first_code(input int i);
        case (i)
            0: return 7'o012;  1: return 7'o045;  2: return 7'o000;
            3: return 7'o046;  4: return 7'o047;  5: return 7'o042;
            6: return 7'o043;  7: return 7'o044;  8: return 7'o001;
            9: return 7'o070;  default: return 7'o042;
        endcase
    endfunction

    function automatic logic [6:0] second_code(input int i);
        case (i)
            0: return 7'o004;  1: return 7'o006;  2: return 7'o067;
            3: return 7'o077;  default: return 7'o071;
        endcase
    endfunction

    // Expected command list for a run whose first k reads return the bit set
    task automatic build(input int k);
        exp_t e;
        q.delete();
        for (int i = 0; i < 11; i++) begin
            e = '{code: first_code(i), data: 36'd0, last: 1'b0, errs: 1'b0,
                  prepoll: (i == 10), grp: 2'd0};
            q.push_back(e);
        end
        for (int i = 0; i <= MAXST; i++) begin
            e = '{code: 7'o162, data: 36'd0, last: 1'b0,
                  errs: (i == MAXST && k > MAXST), prepoll: 1'b0, grp: 2'd1};
            q.push_back(e);
            if (i >= k || i == MAXST) break;
            e = '{code: 7'o002, data: 36'd0, last: 1'b0, errs: 1'b0,
                  prepoll: 1'b1, grp: 2'd2};
            q.push_back(e);
        end
        for (int i = 0; i < 5; i++) begin
            e = '{code: second_code(i), data: (i == 4) ? 36'o120 : 36'd0,
                  last: (i == 4), errs: 1'b0, prepoll: 1'b0, grp: 2'd3};
            q.push_back(e);
        end
        kset   = k;
        rd_idx = 0;
    endtask

    // Responder: acknowledges strobes and checks each command against the queue
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        cmd_done = 1'b0;
        o_last   = 1'b0;
        o_err    = 1'b0;
        if (!rst_n) begin
            pend = 0;
        end else begin
            if (pend) begin
                if (wcnt == 0) begin
                    cmd_done = 1'b1;
                    pend     = 0;
                    o_last   = cur.last;
                    o_err    = cur.errs;
                    if (cur.prepoll) pp_cyc = cyc;
                end else begin
                    wcnt--;
                end
            end else if (stray_en && !cmd_stb) begin
                cmd_done = 1'b1;   // R4: unsolicited acknowledge
            end
            if (cmd_stb) begin
                chk(!pend, "R4 strobe with command outstanding", 1, 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R11 unexpected strobe", cmd_func, 0);
                end else begin
                    e = q.pop_front();
                    case (e.grp)
                        2'd0: begin
                            chk(cmd_func == e.code, "R3 code", cmd_func, e.code);
                            chk(cmd_wdata == e.data, "R3 data", cmd_wdata, e.data);
                        end
                        2'd1: begin
                            chk(cmd_func == e.code, "R5 read code", cmd_func, e.code);
                            chk(cmd_wdata == 0, "R5 read data", cmd_wdata, 0);
                            chk(cyc - pp_cyc == W + 1, "R5 poll delay", cyc - pp_cyc, W + 1);
                            // R6: only vector index 3 carries the status
                            rd_word = (rd_idx < kset) ? 36'h8 : ~36'h8;
                            rd_idx++;
                        end
                        2'd2: begin
                            chk(cmd_func == e.code, "R7 step code", cmd_func, e.code);
                            chk(cmd_wdata == 0, "R7 step data", cmd_wdata, 0);
                        end
                        default: begin
                            chk(cmd_func == e.code, "R9 code", cmd_func, e.code);
                            chk(cmd_wdata == e.data, "R9 data", cmd_wdata, e.data);
                        end
                    endcase
                    cur  = e;
                    pend = 1;
                    wcnt = lat;
                end
            end
        end
    end

    // Reference model of busy, done and error, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0;
        end else if (m_done) begin
            m_done = 0; m_busy = 0;
        end else if (!m_busy) begin
            if (start) begin m_busy = 1; m_err = 0; end
        end else if (cmd_done) begin
            if (o_last) m_done = 1;
            if (o_err)  m_err  = 1;
        end
    end

    // Compare flags with the model every cycle
    always @(negedge clk) begin
        if (mon_en) begin
            chk(busy == m_busy, "R2 busy", busy, m_busy);
            chk(done == m_done, "R10 done", done, m_done);
            chk(error == m_err, "R8 error", error, m_err);
        end
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_idle();
        int n = 0;
        while (!(q.size() == 0 && !busy && !pend)) begin
            @(negedge clk);
            n++;
            if (n > 5000) begin
                chk(1'b0, "R10 run did not finish", q.size(), 0);
                return;
            end
        end
    endtask

    task automatic run(input int k, input int l, input bit stray, input bit extra);
        build(k);
        lat = l;
        stray_en = stray;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra) begin
            repeat (6) @(negedge clk);
            start = 1'b1;                 // R2: ignored while busy
            @(negedge clk); start = 1'b0;
        end
        wait_idle();
        stray_en = 0;
        chk(q.size() == 0, "R9 all commands issued", q.size(), 0);
        chk(error == (k > MAXST), "R8 final error", error, k > MAXST);
        chk(!busy && !done, "R10 idle after run", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !cmd_stb && !error, "R1 flags in reset", {busy, done, cmd_stb, error}, 0);
        rst_n = 1'b1;
        mon_en = 1;
        @(negedge clk);
        chk(!busy && !done && !cmd_stb && !error, "R1 flags after reset", {busy, done, cmd_stb, error}, 0);
        chk(cmd_func == 0 && cmd_wdata == 0, "R1 port idle", cmd_func, 0);

        run(0, 0, 0, 0);   // R6: clear on first read
        run(2, 1, 0, 1);   // R7: two steps, R2 stray start
        run(5, 2, 1, 0);   // R7: five steps then clear, R4 stray acks
        run(6, 0, 0, 0);   // R8: exhausted loop
        repeat (5) @(negedge clk);
        chk(error == 1'b1, "R8 error holds while idle", error, 1);
        run(1, 1, 0, 0);   // R8: cleared by new start

        run(7, 1, 0, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(!error && !busy, "R11 reset clears error", error, 0);

        build(3);
        lat = 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !error && !cmd_stb, "R11 mid-run reset idle", busy, 0);
        repeat (20) @(negedge clk);
        chk(!busy && !cmd_stb, "R11 stays idle", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule